// File: doc/BRIEF.md
# Integrating DAC Pulse Sequencer

This block steps an integrating sample-and-hold DAC through one conversion per request. The output level is set by a single reference pulse whose length, in clock cycles, fixes how far the integrator ramps. No averaged waveform is filtered down to DC. For each accepted request the sequencer does four things in turn:

- It holds the integrator capacitor in discharge.
- It steers the reference into the integrator for the programmed number of cycles.
- It waits a fixed time for the ramp to settle.
- It finishes the request in one of two ways. In emit mode it opens the output multiplexer so that the held ramp charges one channel's hold capacitor. In tune mode it captures the ramp-versus-reference comparator and reports that result.

A host issues a one-cycle start strobe together with these request fields, which are captured at the moment of acceptance:

- mode
- pulse width
- ramp polarity
- channel index

The `busy` flag is high for the whole sequence, and any start strobe seen while it is high is dropped. A one-cycle `doneStb` marks the final cycle of every sequence.

Top module: `ramp_dac_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy` is 0, `dischargeOn` is 1, `refToInteg` is 0, `muxEn` is 0 and `doneStb` is 0.
- R2: A start strobe sampled while idle starts a sequence. In the first cycle after that edge, `busy` is 1. For exactly DISCH_CYC cycles the block is in the discharge phase: `dischargeOn`=1, `refToInteg`=0 and `muxEn`=0.
- R3: Right after discharge, `refToInteg` is 1 for exactly as many cycles as the captured pulse width, and it is 0 in every other cycle. A width of 0 gives no cycle with `refToInteg`=1, and the settle phase then follows discharge directly.
- R4: `dischargeOn` is 0 in exactly these cycles: the pulse cycles, the settle cycles and, in emit mode, the transfer cycles. It is 1 in every other cycle.
- R5: After the pulse the block settles for exactly SETTLE_CYC cycles. `muxEn` is 0 throughout settling, and it is never 1 outside the transfer phase.
- R6: In emit mode (`tuneMode`=0), the settle phase is followed by XFER_CYC cycles with `muxEn`=1 and `muxSel` equal to the captured channel index. `doneStb` is 1 on the last transfer cycle, and the block is idle in the next cycle.
- R7: In tune mode (`tuneMode`=1), `muxEn` stays 0. The settle phase is followed by one evaluation cycle in which `doneStb`=1. In that cycle `tuneResult` equals `cmpIn` as sampled at the clock edge that ends the last settle cycle. `tuneResult` holds that value until the next tune sequence captures a new one.
- R8: `polSel` equals the polarity captured at acceptance (1 = positive ramp, 0 = negative ramp), and it does not change while `busy` is 1.
- R9: A start strobe that arrives while `busy` is 1 is ignored. The running sequence keeps its captured width, mode, polarity and channel, and no new sequence starts after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startStb | input | 1 | One-cycle request strobe |
| tuneMode | input | 1 | 1 = tune request, 0 = emit request |
| pulseWidth | input | WIDTH_W | Pulse length in clock cycles |
| polIn | input | 1 | Ramp polarity for the request |
| chanIn | input | CH_W | Target output channel |
| cmpIn | input | 1 | Ramp-above-reference comparator |
| refToInteg | output | 1 | 1 = reference into integrator, 0 = reference into ground |
| dischargeOn | output | 1 | Integrator discharge switch closed |
| polSel | output | 1 | Ramp polarity select |
| muxEn | output | 1 | Output multiplexer enable |
| muxSel | output | CH_W | Output multiplexer channel |
| busy | output | 1 | Sequence in progress |
| doneStb | output | 1 | Final cycle of a sequence |
| tuneResult | output | 1 | Captured comparator result |

## Verification
Every pulse width from 0 to the largest value of a small configuration is run in both modes, with the polarity and channel varied alongside. This tells the zero-width skip apart from a one-cycle pulse and from full-range counting, and it tells the transfer ending apart from the evaluation ending. In tune runs the comparator is given the wanted level only during the last settle cycle and the opposite level at all other times. A capture taken one cycle early or late therefore shows up as a wrong result. Some runs inject a start strobe with every request field changed: in the second cycle, in the middle, or in the final busy cycle. Each such run must keep its original timing and fields and must not restart.

// File: rtl/ramp_dac_pkg.sv
package ramp_dac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISCH,
    ST_PULSE,
    ST_SETTLE,
    ST_XFER,
    ST_EVAL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic ldDisch;
    logic ldPulse;
    logic ldSettle;
    logic ldXfer;
    logic capCmp;
  } dpCmd_t;

endpackage

// File: rtl/ramp_dac_dp.sv
module ramp_dac_dp
  import ramp_dac_pkg::*;
#(
  parameter int WIDTH_W    = 16,
  parameter int CH_W       = 3,
  parameter int DISCH_CYC  = 8,
  parameter int SETTLE_CYC = 8,
  parameter int XFER_CYC   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [WIDTH_W-1:0] pulseWidth,
  input  logic               tuneMode,
  input  logic               polIn,
  input  logic [CH_W-1:0]    chanIn,
  input  logic               cmpIn,
  output logic               cntZero,
  output logic               widthZero,
  output logic               reqTune,
  output logic               polSel,
  output logic [CH_W-1:0]    muxSel,
  output logic               tuneResult
);

  localparam int CNT_W = WIDTH_W;
  localparam logic [CNT_W-1:0] DISCH_LD  = CNT_W'(DISCH_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] XFER_LD   = CNT_W'(XFER_CYC - 1);

  logic [WIDTH_W-1:0] widthQ;
  logic               tuneQ;
  logic               polQ;
  logic [CH_W-1:0]    chanQ;
  logic [CNT_W-1:0]   phaseCnt;
  logic               resQ;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthQ <= '0;
      tuneQ  <= 1'b0;
      polQ   <= 1'b0;
      chanQ  <= '0;
    end else if (cmd.latchReq) begin
      widthQ <= pulseWidth;
      tuneQ  <= tuneMode;
      polQ   <= polIn;
      chanQ  <= chanIn;
    end
  end

  // shared phase down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (cmd.ldDisch)      phaseCnt <= DISCH_LD;
    else if (cmd.ldPulse)      phaseCnt <= widthQ - CNT_W'(1);
    else if (cmd.ldSettle)     phaseCnt <= SETTLE_LD;
    else if (cmd.ldXfer)       phaseCnt <= XFER_LD;
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - CNT_W'(1);
  end

  // comparator capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           resQ <= 1'b0;
    else if (cmd.capCmp) resQ <= cmpIn;
  end

  assign cntZero    = (phaseCnt == '0);
  assign widthZero  = (widthQ == '0);
  assign reqTune    = tuneQ;
  assign polSel     = polQ;
  assign muxSel     = chanQ;
  assign tuneResult = resQ;

endmodule

// File: rtl/ramp_dac_ctrl.sv
module ramp_dac_ctrl
  import ramp_dac_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startStb,
  input  logic   cntZero,
  input  logic   widthZero,
  input  logic   reqTune,
  output dpCmd_t cmd,
  output logic   refToInteg,
  output logic   dischargeOn,
  output logic   muxEn,
  output logic   busy,
  output logic   doneStb
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    cmd      = '0;
    case (state)
      ST_IDLE: begin
        if (startStb) begin
          cmd.latchReq = 1'b1;
          cmd.ldDisch  = 1'b1;
          stateNxt     = ST_DISCH;
        end
      end
      ST_DISCH: begin
        if (cntZero) begin
          if (widthZero) begin
            cmd.ldSettle = 1'b1;
            stateNxt     = ST_SETTLE;
          end else begin
            cmd.ldPulse = 1'b1;
            stateNxt    = ST_PULSE;
          end
        end
      end
      ST_PULSE: begin
        if (cntZero) begin
          cmd.ldSettle = 1'b1;
          stateNxt     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (cntZero) begin
          if (reqTune) begin
            cmd.capCmp = 1'b1;
            stateNxt   = ST_EVAL;
          end else begin
            cmd.ldXfer = 1'b1;
            stateNxt   = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (cntZero) stateNxt = ST_IDLE;
      end
      ST_EVAL:  stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  assign refToInteg  = (state == ST_PULSE);
  assign dischargeOn = !(state inside {ST_PULSE, ST_SETTLE, ST_XFER});
  assign muxEn       = (state == ST_XFER);
  assign busy        = (state != ST_IDLE);
  assign doneStb     = (state == ST_EVAL) || ((state == ST_XFER) && cntZero);

endmodule

// File: rtl/ramp_dac_seq.sv
module ramp_dac_seq
  import ramp_dac_pkg::*;
#(
  parameter int WIDTH_W    = 16,
  parameter int CHAN_N     = 8,
  parameter int DISCH_CYC  = 8,
  parameter int SETTLE_CYC = 8,
  parameter int XFER_CYC   = 16,
  localparam int CH_W      = (CHAN_N > 1) ? $clog2(CHAN_N) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic               tuneMode,
  input  logic [WIDTH_W-1:0] pulseWidth,
  input  logic               polIn,
  input  logic [CH_W-1:0]    chanIn,
  input  logic               cmpIn,
  output logic               refToInteg,
  output logic               dischargeOn,
  output logic               polSel,
  output logic               muxEn,
  output logic [CH_W-1:0]    muxSel,
  output logic               busy,
  output logic               doneStb,
  output logic               tuneResult
);

  dpCmd_t cmd;
  logic   cntZero, widthZero, reqTune;

  ramp_dac_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStb   (startStb),
    .cntZero    (cntZero),
    .widthZero  (widthZero),
    .reqTune    (reqTune),
    .cmd        (cmd),
    .refToInteg (refToInteg),
    .dischargeOn(dischargeOn),
    .muxEn      (muxEn),
    .busy       (busy),
    .doneStb    (doneStb)
  );

  ramp_dac_dp #(
    .WIDTH_W   (WIDTH_W),
    .CH_W      (CH_W),
    .DISCH_CYC (DISCH_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .XFER_CYC  (XFER_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .pulseWidth(pulseWidth),
    .tuneMode  (tuneMode),
    .polIn     (polIn),
    .chanIn    (chanIn),
    .cmpIn     (cmpIn),
    .cntZero   (cntZero),
    .widthZero (widthZero),
    .reqTune   (reqTune),
    .polSel    (polSel),
    .muxSel    (muxSel),
    .tuneResult(tuneResult)
  );

endmodule

// File: rtl/ramp_dac_chk.sv
module ramp_dac_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            startStb,
  input logic            refToInteg,
  input logic            dischargeOn,
  input logic            polSel,
  input logic            muxEn,
  input logic [CH_W-1:0] muxSel,
  input logic            busy,
  input logic            doneStb
);

  a_r1_idle_safe: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (dischargeOn && !refToInteg && !muxEn && !doneStb));

  a_r2_start_disch: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startStb) |=> (busy && dischargeOn && !refToInteg));

  a_r4_pulse_nodisch: assert property (@(posedge clk) disable iff (!rstN)
    refToInteg |-> (!dischargeOn && !muxEn));

  a_r5_mux_ramp_held: assert property (@(posedge clk) disable iff (!rstN)
    muxEn |-> (!dischargeOn && !refToInteg && busy));

  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !busy);

  a_r6_sel_stable: assert property (@(posedge clk) disable iff (!rstN)
    (muxEn && busy) |=> (!muxEn || $stable(muxSel)));

  a_r8_pol_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(polSel)));

endmodule

bind ramp_dac_seq ramp_dac_chk #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startStb   (startStb),
  .refToInteg (refToInteg),
  .dischargeOn(dischargeOn),
  .polSel     (polSel),
  .muxEn      (muxEn),
  .muxSel     (muxSel),
  .busy       (busy),
  .doneStb    (doneStb)
);

// File: tb/sim_ramp_dac_seq.sv
`timescale 1ns/1ps
module sim_ramp_dac_seq;

  localparam int W   = 5;
  localparam int NCH = 4;
  localparam int CHW = 2;
  localparam int D   = 3;
  localparam int S   = 2;
  localparam int X   = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startStb = 1'b0;
  logic           tuneMode = 1'b0;
  logic [W-1:0]   pulseWidth = '0;
  logic           polIn = 1'b0;
  logic [CHW-1:0] chanIn = '0;
  logic           cmpIn = 1'b0;
  logic           refToInteg, dischargeOn, polSel, muxEn, busy, doneStb, tuneResult;
  logic [CHW-1:0] muxSel;

  int nVec = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ramp_dac_seq #(
    .WIDTH_W(W), .CHAN_N(NCH), .DISCH_CYC(D), .SETTLE_CYC(S), .XFER_CYC(X)
  ) u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .tuneMode(tuneMode),
    .pulseWidth(pulseWidth), .polIn(polIn), .chanIn(chanIn), .cmpIn(cmpIn),
    .refToInteg(refToInteg), .dischargeOn(dischargeOn), .polSel(polSel),
    .muxEn(muxEn), .muxSel(muxSel), .busy(busy), .doneStb(doneStb),
    .tuneResult(tuneResult)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // intrude: 0 none, 1 second cycle, 2 middle, 3 last busy cycle
  task automatic runSeq(input bit tune, input int width, input bit pol,
                        input int chan, input bit cmpWant, input int intrude);
    int pEnd, sEnd, endT, hitAt;
    pEnd  = D + width;
    sEnd  = pEnd + S;
    endT  = sEnd + (tune ? 1 : X);
    hitAt = (intrude == 1) ? 1 : (intrude == 2) ? endT / 2 : (intrude == 3) ? endT - 1 : -1;
    @(negedge clk);
    startStb   = 1'b1;
    tuneMode   = tune;
    pulseWidth = W'(width);
    polIn      = pol;
    chanIn     = CHW'(chan);
    cmpIn      = ~cmpWant;
    for (int i = 0; i < endT + 2; i++) begin
      @(negedge clk);
      begin
        bit eBusy, eRef, eMux, eDis, eDone;
        eBusy = (i < endT);
        eRef  = (i >= D) && (i < pEnd);
        eMux  = !tune && (i >= sEnd) && (i < endT);
        eDis  = !((i >= D) && (i < (tune ? sEnd : endT)));
        eDone = (i == endT - 1);
        check((i < D) ? "R2" : (i >= endT) ? "R9" : "R2", "busy", int'(busy), int'(eBusy));
        check("R3", "refToInteg", int'(refToInteg), int'(eRef));
        check("R4", "dischargeOn", int'(dischargeOn), int'(eDis));
        check(tune ? "R7" : "R5", "muxEn", int'(muxEn), int'(eMux));
        check(tune ? "R7" : "R6", "doneStb", int'(doneStb), int'(eDone));
        if (eBusy) check("R8", "polSel", int'(polSel), int'(pol));
        if (eMux)  check("R6", "muxSel", int'(muxSel), chan);
        if (tune && i >= endT - 1) check("R7", "tuneResult", int'(tuneResult), int'(cmpWant));
        if (i >= endT) check("R1", "idle", int'({refToInteg, muxEn, doneStb}), 0);
      end
      // drive for the coming edge
      startStb = (i == hitAt);
      if (i == hitAt) begin
        tuneMode   = ~tune;
        pulseWidth = ~W'(width);
        polIn      = ~pol;
        chanIn     = CHW'(chan + 1);
      end
      cmpIn = (i == sEnd - 1) ? cmpWant : ~cmpWant;
    end
    startStb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset dischargeOn", int'(dischargeOn), 1);
    check("R1", "reset refToInteg", int'(refToInteg), 0);
    check("R1", "reset muxEn", int'(muxEn), 0);
    check("R1", "reset doneStb", int'(doneStb), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "idle after release", int'({busy, refToInteg, muxEn}), 0);
    // R3 R6 R7: sweep every width in both modes
    for (int w = 0; w < (1 << W); w++) begin
      for (int t = 0; t < 2; t++) begin
        runSeq(t[0], w, w[0] ^ t[0], (w + t) % NCH, w[1] ^ t[0], 0);
      end
    end
    // R9: intruding start strobes
    for (int k = 1; k < 4; k++) begin
      for (int t = 0; t < 2; t++) begin
        runSeq(t[0], 2 + k, k[0], k % NCH, t[0], k);
        runSeq(t[0], 0, ~k[0], (k + 2) % NCH, ~t[0], k);
      end
    end
    // R7: tuneResult holds across an emit sequence
    runSeq(1'b1, 4, 1'b0, 1, 1'b1, 0);
    runSeq(1'b0, 3, 1'b1, 2, 1'b0, 0);
    check("R7", "tuneResult held", int'(tuneResult), 1);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nVec++;
      nErr++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

endmodule